// File: doc/BRIEF.md
# I2C Controller Event Flag and Interrupt Register

This block is the event and interrupt register of an I2C controller. Eight event flags latch single-cycle pulses from the transfer engine: bus free, transfer complete, missing acknowledge, oversize transfer, early termination, arbitration loss, slave stop and slave event. Each flag has an enable bit, and a registered interrupt line is raised whenever an enabled flag is set. The register can be written at three byte offsets. One offset loads the register, one sets the bits written as 1 and one clears the bits written as 1. The set and clear offsets let software change single bits without a read-modify-write.

From the error flags the block also produces an error class for the driver. A missing acknowledge reports "no device" and overrides every other error. Early termination, arbitration loss, slave stop and slave event report a generic I/O error. Bus free, complete and oversize leave the class unchanged. Bit 28 of the register is a one-shot command: writing 1 to it sends a single-cycle release pulse to a transfer engine that has stopped after a NAK. The bit always reads back as 0.

Top module: `irq_status_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the flags, enables, `irqOut` and `nakRelease` are 0 and `errClass` is 2'b00.
- R2: `rdData` holds the flags in bits 7:0 (7 bus free, 6 complete, 5 no acknowledge, 4 oversize, 3 early termination, 2 arbitration loss, 1 slave stop, 0 slave event). It holds the enable of flag i in bit i+8. All bits from 16 to 31, bit 28 included, read as 0.
- R3: A write at byte offset 0x0 loads flags and enables from `wrData[15:0]`. The new value is visible on `rdData` in the cycle after the write edge.
- R4: A write at offset 0x4 sets every flag and enable bit whose `wrData` bit is 1 and leaves all the other bits unchanged.
- R5: A write at offset 0x8 clears every flag and enable bit whose `wrData` bit is 1 and leaves all the other bits unchanged.
- R6: A write at any other offset, for example 0xC, changes neither the register nor `nakRelease`.
- R7: An `evtPulse` bit sets its flag at the next edge. If a write at offset 0x0 or 0x8 would clear or zero the same flag in that cycle, the event still sets it.
- R8: `irqOut` is registered. In each cycle it equals the OR over all eight bits of (flag AND enable) as those bits stood one cycle earlier.
- R9: `errClass` is decoded from the current flags. It is 2'b10 whenever bit 5 is set. It is 2'b01 when bit 5 is clear and any of bits 3..0 is set. Otherwise it is 2'b00, so bits 7, 6 and 4 never affect it.
- R10: Writing 1 to `wrData[28]` at offset 0x0 or 0x4 makes `nakRelease` 1 for exactly the one cycle after the write edge. Writing it at offset 0x8 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 4 | Byte offset of the write (0x0 load, 0x4 set, 0x8 clear) |
| wrData | input | 32 | Write data |
| evtPulse | input | 8 | Single-cycle event pulses from the transfer engine, one per flag |
| rdData | output | 32 | Current register value |
| irqOut | output | 1 | Registered interrupt request |
| errClass | output | 2 | Error class: 00 none, 01 I/O error, 10 no device |
| nakRelease | output | 1 | Single-cycle release pulse for an engine stopped after a NAK |

## Verification
Writes and events are sampled at one edge, and their effect on `rdData`, `errClass` and `nakRelease` is due one cycle later. `irqOut` is due one cycle after that, because it is registered from the stored flags. The bench drives its inputs on falling edges and checks the register side half a cycle after the write edge. It checks the interrupt after one more full cycle in which nothing is driven. The flag and enable space is swept through all 256 flag values, and each alias and any same-cycle clash between an event and a write are tested against a model of the register in the bench.

// File: rtl/isr_pkg.sv
package isr_pkg;

  // Flag positions that the error decoder and the bench depend on
  localparam int FLAG_BUS_FREE  = 7;
  localparam int FLAG_COMPLETE  = 6;
  localparam int FLAG_NO_ACK    = 5;
  localparam int FLAG_OVERSIZE  = 4;
  localparam int FLAG_EARLY     = 3;
  localparam int FLAG_ARB_LOSS  = 2;
  localparam int FLAG_SLV_STOP  = 1;
  localparam int FLAG_SLV_EVENT = 0;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_IO    = 2'b01,
    ERR_NODEV = 2'b10
  } errClass_e;

  // Strobes from the address decoder to the register datapath
  typedef struct packed {
    logic ldPlain;
    logic ldSet;
    logic ldClr;
    logic nakFire;
  } isrStrobe_t;

endpackage

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int OFS_SET = 4,
  parameter int OFS_CLR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              nakBit,
  output isrStrobe_t        strobe,
  output logic              nakRelease
);

  localparam logic [ADDR_W-1:0] ADDR_PLAIN = '0;
  localparam logic [ADDR_W-1:0] ADDR_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] ADDR_CLR   = ADDR_W'(OFS_CLR);

  logic hitPlain;
  logic hitSet;
  logic hitClr;

  always_comb begin
    hitPlain = wrEn && (wrAddr == ADDR_PLAIN);
    hitSet   = wrEn && (wrAddr == ADDR_SET);
    hitClr   = wrEn && (wrAddr == ADDR_CLR);
    strobe.ldPlain = hitPlain;
    strobe.ldSet   = hitSet;
    strobe.ldClr   = hitClr;
    // The command bit acts only when it is written as 1, never through the clear alias
    strobe.nakFire = (hitPlain || hitSet) && nakBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nakRelease <= 1'b0;
    else       nakRelease <= strobe.nakFire;
  end

endmodule

// File: rtl/isr_err_encode.sv
module isr_err_encode
  import isr_pkg::*;
#(
  parameter int NUM_FLAGS = 8
) (
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [1:0]           errClass
);

  logic ioErr;

  always_comb begin
    ioErr = flags[FLAG_EARLY] | flags[FLAG_ARB_LOSS] |
            flags[FLAG_SLV_STOP] | flags[FLAG_SLV_EVENT];
    if (flags[FLAG_NO_ACK]) errClass = ERR_NODEV;
    else if (ioErr)         errClass = ERR_IO;
    else                    errClass = ERR_NONE;
  end

endmodule

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
#(
  parameter int NUM_FLAGS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  isrStrobe_t             strobe,
  input  logic [2*NUM_FLAGS-1:0] wrBits,
  input  logic [NUM_FLAGS-1:0]   evtPulse,
  output logic [NUM_FLAGS-1:0]   flagQ,
  output logic [NUM_FLAGS-1:0]   enQ,
  output logic                   irqOut
);

  logic [NUM_FLAGS-1:0] wrFlag;
  logic [NUM_FLAGS-1:0] wrEnab;
  logic [NUM_FLAGS-1:0] flagNext;
  logic [NUM_FLAGS-1:0] enNext;

  always_comb begin
    wrFlag = wrBits[NUM_FLAGS-1:0];
    wrEnab = wrBits[2*NUM_FLAGS-1:NUM_FLAGS];
    flagNext = flagQ;
    enNext   = enQ;
    if (strobe.ldPlain) begin
      flagNext = wrFlag;
      enNext   = wrEnab;
    end else if (strobe.ldSet) begin
      flagNext = flagQ | wrFlag;
      enNext   = enQ | wrEnab;
    end else if (strobe.ldClr) begin
      flagNext = flagQ & ~wrFlag;
      enNext   = enQ & ~wrEnab;
    end
    // A hardware event overrides any software write to the same flag
    flagNext = flagNext | evtPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= '0;
      enQ    <= '0;
      irqOut <= 1'b0;
    end else begin
      flagQ  <= flagNext;
      enQ    <= enNext;
      irqOut <= |(flagQ & enQ);
    end
  end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import isr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int NUM_FLAGS   = 8,
  parameter int NAK_CMD_BIT = 28,
  parameter int OFS_SET     = 4,
  parameter int OFS_CLR     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_FLAGS-1:0] evtPulse,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic [1:0]           errClass,
  output logic                 nakRelease
);

  localparam int REG_W = 2 * NUM_FLAGS;

  isrStrobe_t           strobe;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [NUM_FLAGS-1:0] enQ;

  isr_ctrl #(
    .ADDR_W (ADDR_W),
    .OFS_SET(OFS_SET),
    .OFS_CLR(OFS_CLR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .nakBit    (wrData[NAK_CMD_BIT]),
    .strobe    (strobe),
    .nakRelease(nakRelease)
  );

  isr_datapath #(
    .NUM_FLAGS(NUM_FLAGS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrBits  (wrData[REG_W-1:0]),
    .evtPulse(evtPulse),
    .flagQ   (flagQ),
    .enQ     (enQ),
    .irqOut  (irqOut)
  );

  isr_err_encode #(
    .NUM_FLAGS(NUM_FLAGS)
  ) u_err (
    .flags   (flagQ),
    .errClass(errClass)
  );

  // The command bit has no storage and reads back as zero
  assign rdData = {{(DATA_W-REG_W){1'b0}}, enQ, flagQ};

endmodule

// File: rtl/irq_status_reg_chk.sv
module irq_status_reg_chk #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 4,
  parameter int NUM_FLAGS   = 8,
  parameter int NAK_CMD_BIT = 28
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [DATA_W-1:0]    wrData,
  input logic [NUM_FLAGS-1:0] evtPulse,
  input logic [DATA_W-1:0]    rdData,
  input logic                 irqOut,
  input logic [1:0]           errClass,
  input logic                 nakRelease
);
  localparam int REG_W = 2 * NUM_FLAGS;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:REG_W] == '0); // R2

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((rdData[NUM_FLAGS-1:0] & $past(evtPulse)) == $past(evtPulse))); // R7

  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |($past(rdData[NUM_FLAGS-1:0]) & $past(rdData[REG_W-1:NUM_FLAGS]))); // R8

  AST_NOACK_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    rdData[isr_pkg::FLAG_NO_ACK] |-> errClass == 2'b10); // R9

  AST_NO_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (errClass == 2'b00) |-> ((rdData[7:0] & 8'h2F) == 8'h00)); // R9

  AST_NAK_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    nakRelease |-> ($past(wrEn) && $past(wrData[NAK_CMD_BIT]))); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && evtPulse == '0) |=> $stable(rdData)); // R6

endmodule

bind irq_status_reg irq_status_reg_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .NUM_FLAGS  (NUM_FLAGS),
  .NAK_CMD_BIT(NAK_CMD_BIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .evtPulse  (evtPulse),
  .rdData    (rdData),
  .irqOut    (irqOut),
  .errClass  (errClass),
  .nakRelease(nakRelease)
);

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = 4'h0;
  logic [31:0] wrData = '0;
  logic [7:0]  evtPulse = '0;
  logic [31:0] rdData;
  logic        irqOut;
  logic [1:0]  errClass;
  logic        nakRelease;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] mFlag = '0;
  logic [7:0] mEn = '0;

  always #2.5 clk = ~clk;

  irq_status_reg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtPulse(evtPulse), .rdData(rdData), .irqOut(irqOut),
    .errClass(errClass), .nakRelease(nakRelease)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expErr(input logic [7:0] f);
    if (f[5])                return 2'b10;
    else if ((f & 8'h0F) != 0) return 2'b01;
    else                     return 2'b00;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Apply one cycle of write and event, update the model, return at the next falling edge
  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d, input logic [7:0] e);
    wrEn = we; wrAddr = a; wrData = d; evtPulse = e;
    tick();
    wrEn = 1'b0; wrData = '0; evtPulse = '0;
    if (we) begin
      case (a)
        4'h0: begin mFlag = d[7:0]; mEn = d[15:8]; end
        4'h4: begin mFlag = mFlag | d[7:0]; mEn = mEn | d[15:8]; end
        4'h8: begin mFlag = mFlag & ~d[7:0]; mEn = mEn & ~d[15:8]; end
        default: ;
      endcase
    end
    mFlag = mFlag | e;
  endtask

  task automatic checkReg(input string req);
    check(req, rdData, {16'h0, mEn, mFlag});
    check({req, "/R9"}, {30'h0, errClass}, {30'h0, expErr(mFlag)});
  endtask

  task automatic checkIrq(input string req);
    tick();
    check(req, {31'h0, irqOut}, {31'h0, |(mFlag & mEn)});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reg", rdData, 32'h0);
    check("R1 irq", {31'h0, irqOut}, 32'h0);
    check("R1 nak", {31'h0, nakRelease}, 32'h0);
    check("R1 err", {30'h0, errClass}, 32'h0);
    rstN = 1'b1;
    tick();
    check("R1 after", rdData, 32'h0);

    // R3/R2/R8/R9: sweep of all flag values with varied enables
    for (int f = 0; f < 256; f++) begin
      logic [7:0] en;
      en = 8'((f * 37 + 11) & 255);
      if (f % 17 == 0) en = 8'h00;
      cyc(1'b1, 4'h0, {8'hA5, 8'h00, en, 8'(f)}, 8'h00);
      checkReg("R3 plain");
      checkIrq("R8 irq");
    end

    // R4/R5/R6: walk across the aliases
    for (int i = 0; i < 96; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      a = 4'((i % 4) * 4);
      d = 32'((i * 32'h9E37) ^ (i << 9)) & 32'hEFFF_FFFF;
      cyc(1'b1, a, d, 8'h00);
      if (a == 4'h4)      checkReg("R4 set");
      else if (a == 4'h8) checkReg("R5 clear");
      else if (a == 4'hC) checkReg("R6 ignored");
      else                checkReg("R3 plain");
      checkIrq("R8 irq alias");
    end

    // R7: events alone, each flag
    cyc(1'b1, 4'h0, 32'h0000_FF00, 8'h00);
    for (int b = 0; b < 8; b++) begin
      cyc(1'b0, 4'h0, 32'h0, 8'(1 << b));
      checkReg("R7 event");
    end
    // R7: event beats a clear to the same flag
    cyc(1'b1, 4'h8, 32'h0000_00FF, 8'h24);
    checkReg("R7 vs clear");
    check("R7 vs clear value", rdData, 32'h0000_FF24);
    // R7: event beats a plain write of zero
    cyc(1'b1, 4'h0, 32'h0000_0300, 8'h81);
    check("R7 vs plain", rdData, 32'h0000_0381);
    checkIrq("R8 irq after event");

    // R9: priority of no acknowledge over I/O errors
    cyc(1'b1, 4'h0, 32'h0000_002F, 8'h00);
    check("R9 nodev priority", {30'h0, errClass}, 32'h2);
    cyc(1'b1, 4'h8, 32'h0000_0020, 8'h00);
    check("R9 io", {30'h0, errClass}, 32'h1);
    cyc(1'b1, 4'h0, 32'h0000_00D0, 8'h00);
    check("R9 none", {30'h0, errClass}, 32'h0);

    // R10: one-shot release command
    cyc(1'b1, 4'h0, 32'h1000_0000, 8'h00);
    check("R10 plain pulse", {31'h0, nakRelease}, 32'h1);
    check("R10/R2 reads zero", rdData, {16'h0, mEn, mFlag});
    tick();
    check("R10 single cycle", {31'h0, nakRelease}, 32'h0);
    cyc(1'b1, 4'h4, 32'h1000_0000, 8'h00);
    check("R10 set pulse", {31'h0, nakRelease}, 32'h1);
    tick();
    check("R10 set single", {31'h0, nakRelease}, 32'h0);
    cyc(1'b1, 4'h8, 32'h1000_0000, 8'h00);
    check("R10 clear no pulse", {31'h0, nakRelease}, 32'h0);
    cyc(1'b1, 4'hC, 32'h1000_FFFF, 8'h00);
    check("R6 no pulse", {31'h0, nakRelease}, 32'h0);
    checkReg("R6 no change");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule